// File: doc/BRIEF.md
# Quarter-Wave NCO Phase and Table-Address Generator

This block drives the read side of a numerically controlled oscillator whose sample table holds only the first quarter of one cosine period. It keeps an integer phase that steps once per output sample by a programmable phase step. The phase wraps modulo a full period of `PERIOD` units. For each phase it produces two addresses into that one table and two sign flags: one address and flag for the in-phase (cosine) value, one for the quadrature (sine) value. Downstream logic reads the two table entries and negates each one where its flag is set, which gives a complex exponential at a discrete frequency proportional to the step.

Every frequency the oscillator must produce is an integer multiple of one base spacing. The phase therefore has no fractional bits. The wrap is a compare and a subtract, and the whole path from phase to addresses is built from adders and comparators only.

A load strobe restarts the phase at zero and captures a new step. An advance enable moves the phase by one step. The outputs are a pure function of the held phase, so they stay constant for as long as the phase is not advanced.

Top module: `qnco_addr_gen`

## Requirements
- R1: While and after reset, before any load or advance, the phase is 0: `cos_idx` = 0, `sin_idx` = `PERIOD/4`−1, `cos_neg` = 0, `sin_neg` = 0.
- R2: When `load` is 1 at a rising clock edge, the phase becomes 0 and `step_in` is captured as the new step. `load` takes priority over `adv` at the same edge.
- R3: When `adv` is 1 and `load` is 0 at a rising edge, the captured step is added to the phase. With both `load` and `adv` at 0, all four outputs keep their values.
- R4: When the sum of phase and step is `PERIOD` or more, `PERIOD` is subtracted. The phase always stays below `PERIOD` (the step is required to be below `PERIOD`).
- R5: The quadrant q is 0, 1, 2 or 3, according to whether the phase is below `PERIOD/4`, below `PERIOD/2`, below `3*PERIOD/4`, or at or above `3*PERIOD/4`.
- R6: With offset o = phase − q·`PERIOD/4`, the cosine fold c is o for q = 0 and q = 2, and `PERIOD/4` − o for q = 1 and q = 3. `cos_idx` equals c, except that c = `PERIOD/4` is clamped to `PERIOD/4`−1.
- R7: `sin_idx` equals `PERIOD/4` − c, except that a value of `PERIOD/4` is clamped to `PERIOD/4`−1.
- R8: `cos_neg` is 1 exactly in quadrants 1 and 2. `sin_neg` is 1 exactly in quadrants 2 and 3.
- R9: A step of 0 keeps the phase, and so all outputs, constant under advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Restart phase at zero and capture `step_in` |
| step_in | input | PH_W | Phase step (frequency control word), below `PERIOD` |
| adv | input | 1 | Advance the phase by one step |
| cos_idx | output | IDX_W | Table address for the in-phase magnitude |
| sin_idx | output | IDX_W | Table address for the quadrature magnitude |
| cos_neg | output | 1 | Negate the in-phase table value |
| sin_neg | output | 1 | Negate the quadrature table value |

## Verification
A corrupted phase register or step register shows up at the ports on the first output after the bad edge. Both indices and both flags are decoded combinationally from the phase, so there is no latency in between. A wrong wrap moves every later sample by the size of the error. The bench therefore checks after every edge against a running model of the phase. It steps exactly onto the quadrant thresholds, where a wrong compare or a missing clamp is visible at once as an index of `PERIOD/4` or as a flag flipped one sample early. It also uses the largest legal step, so that the wrap path is taken on almost every advance.

// File: rtl/qnco_addr_gen.sv
module qnco_addr_gen #(
  parameter int unsigned PERIOD = 24576,
  parameter int unsigned PH_W   = $clog2(PERIOD),
  parameter int unsigned IDX_W  = $clog2(PERIOD / 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PH_W-1:0]  step_in,
  input  logic             adv,
  output logic [IDX_W-1:0] cos_idx,
  output logic [IDX_W-1:0] sin_idx,
  output logic             cos_neg,
  output logic             sin_neg
);
  localparam int unsigned QTR = PERIOD / 4;
  localparam logic [PH_W:0]    FULL_W = (PH_W+1)'(PERIOD);
  localparam logic [PH_W-1:0]  Q1_W   = PH_W'(QTR);
  localparam logic [PH_W-1:0]  Q2_W   = PH_W'(2 * QTR);
  localparam logic [PH_W-1:0]  Q3_W   = PH_W'(3 * QTR);
  localparam logic [IDX_W:0]   QTR_W  = (IDX_W+1)'(QTR);
  localparam logic [IDX_W-1:0] LAST_W = IDX_W'(QTR - 1);

  logic [PH_W-1:0]  phase_q, step_q, base, off;
  logic [PH_W:0]    sum;
  logic [1:0]       quad;
  logic [IDX_W:0]   cfold, sfold;

  assign sum = {1'b0, phase_q} + {1'b0, step_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      step_q  <= '0;
    end else if (load) begin
      phase_q <= '0;
      step_q  <= step_in;
    end else if (adv) begin
      phase_q <= (sum >= FULL_W) ? PH_W'(sum - FULL_W) : sum[PH_W-1:0];
    end
  end

  always_comb begin
    if (phase_q >= Q3_W) begin
      quad = 2'd3; base = Q3_W;
    end else if (phase_q >= Q2_W) begin
      quad = 2'd2; base = Q2_W;
    end else if (phase_q >= Q1_W) begin
      quad = 2'd1; base = Q1_W;
    end else begin
      quad = 2'd0; base = '0;
    end
  end

  assign off   = phase_q - base;
  assign cfold = quad[0] ? QTR_W - off[IDX_W:0] : off[IDX_W:0];
  assign sfold = QTR_W - cfold;

  assign cos_idx = (cfold == QTR_W) ? LAST_W : cfold[IDX_W-1:0];
  assign sin_idx = (sfold == QTR_W) ? LAST_W : sfold[IDX_W-1:0];
  assign cos_neg = quad[0] ^ quad[1];
  assign sin_neg = quad[1];
endmodule

// File: rtl/qnco_addr_gen_chk.sv
module qnco_addr_gen_chk #(
  parameter int unsigned PERIOD = 24576,
  parameter int unsigned PH_W   = $clog2(PERIOD),
  parameter int unsigned IDX_W  = $clog2(PERIOD / 4)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             adv,
  input logic [PH_W-1:0]  phase_q,
  input logic [IDX_W-1:0] cos_idx,
  input logic [IDX_W-1:0] sin_idx,
  input logic             cos_neg,
  input logic             sin_neg
);
  localparam int unsigned QTR = PERIOD / 4;

  a_r4_phase_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_q) < PERIOD);

  a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cos_idx == '0) && !cos_neg && !sin_neg);

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(cos_idx) && $stable(sin_idx) && $stable(cos_neg) && $stable(sin_neg));

  a_r6_cos_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cos_idx) < QTR);

  a_r7_indices_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cos_idx) + int'(sin_idx) == QTR) || (int'(cos_idx) == QTR - 1) || (int'(sin_idx) == QTR - 1));
endmodule

bind qnco_addr_gen qnco_addr_gen_chk #(.PERIOD(PERIOD), .PH_W(PH_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .phase_q(phase_q),
  .cos_idx(cos_idx), .sin_idx(sin_idx), .cos_neg(cos_neg), .sin_neg(sin_neg)
);

// File: tb/sim_qnco_addr_gen.sv
module sim_qnco_addr_gen;
  localparam int PERIOD = 24576;
  localparam int QTR    = PERIOD / 4;
  localparam int PH_W   = 15;
  localparam int IDX_W  = 13;
  localparam int NV     = 22;

  // row = {load, adv, step}
  localparam logic [16:0] VEC [0:NV-1] = '{
    {2'b10, 15'd1000}, {2'b01, 15'd0}, {2'b01, 15'd0}, {2'b01, 15'd0},
    {2'b00, 15'd0},    {2'b00, 15'd0}, {2'b01, 15'd0},
    {2'b10, 15'd6144}, {2'b01, 15'd0}, {2'b01, 15'd0}, {2'b01, 15'd0},
    {2'b01, 15'd0},    {2'b01, 15'd0},
    {2'b10, 15'd24575},{2'b01, 15'd0}, {2'b01, 15'd0}, {2'b01, 15'd0},
    {2'b11, 15'd5000}, {2'b01, 15'd0}, {2'b01, 15'd0},
    {2'b10, 15'd0},    {2'b01, 15'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, adv = 1'b0;
  logic [PH_W-1:0] step_in = '0;
  logic [IDX_W-1:0] cos_idx, sin_idx;
  logic cos_neg, sin_neg;
  int total = 0, bad = 0;
  int m_ph = 0, m_st = 0;

  always #4 clk = ~clk;

  qnco_addr_gen u0 (.clk(clk), .rst_n(rst_n), .load(load), .step_in(step_in), .adv(adv),
    .cos_idx(cos_idx), .sin_idx(sin_idx), .cos_neg(cos_neg), .sin_neg(sin_neg));

  function automatic logic [27:0] expect_of(input int ph);
    int q, o, c, s, ci, si;
    q = ph / QTR;
    o = ph % QTR;
    c = (q % 2 == 1) ? QTR - o : o;
    s = QTR - c;
    ci = (c == QTR) ? QTR - 1 : c;
    si = (s == QTR) ? QTR - 1 : s;
    return {IDX_W'(ci), IDX_W'(si), (q == 1 || q == 2), (q >= 2)};
  endfunction

  task automatic chk(input string tag, input logic [27:0] exp);
    logic [27:0] act;
    act = {cos_idx, sin_idx, cos_neg, sin_neg};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got cos=%0d sin=%0d cn=%0b sn=%0b expected cos=%0d sin=%0d cn=%0b sn=%0b",
        tag, act[27:15], act[14:2], act[1], act[0], exp[27:15], exp[14:2], exp[1], exp[0]);
    end
  endtask

  task automatic cyc(input logic l, input logic a, input logic [PH_W-1:0] s);
    @(negedge clk);
    load = l; adv = a; step_in = s;
    @(posedge clk);
    #1;
    load = 1'b0; adv = 1'b0;
    if (l) begin m_ph = 0; m_st = int'(s); end
    else if (a) m_ph = (m_ph + m_st) % PERIOD;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad + 0 * total);
    $finish;
  end

  initial begin
    #2;
    chk("R1 in reset", {13'd0, 13'd6143, 1'b0, 1'b0});
    #20 rst_n = 1'b1;
    cyc(1'b0, 1'b1, 15'd0);
    chk("R1 after reset", {13'd0, 13'd6143, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][16], VEC[i][15], VEC[i][14:0]);
      if (VEC[i][16]) chk("R2 load", expect_of(m_ph));
      else if (VEC[i][15]) chk("R3 R4 R5 R6 R7 R8 advance", expect_of(m_ph));
      else chk("R3 idle hold", expect_of(m_ph));
    end

    // directed: quadrant boundaries with a quarter-period step
    cyc(1'b1, 1'b0, 15'd6144);
    cyc(1'b0, 1'b1, 15'd0);
    chk("R6 R8 phase QTR q1", {13'd6143, 13'd0, 1'b1, 1'b0});
    cyc(1'b0, 1'b1, 15'd0);
    chk("R7 R8 phase HALF q2", {13'd0, 13'd6143, 1'b1, 1'b1});
    cyc(1'b0, 1'b1, 15'd0);
    chk("R5 R6 phase 3QTR q3", {13'd6143, 13'd0, 1'b0, 1'b1});
    cyc(1'b0, 1'b1, 15'd0);
    chk("R4 exact wrap to zero", {13'd0, 13'd6143, 1'b0, 1'b0});

    // largest step
    cyc(1'b1, 1'b0, 15'd24575);
    cyc(1'b0, 1'b1, 15'd0);
    chk("R6 R8 phase 24575", {13'd1, 13'd6143, 1'b0, 1'b1});
    cyc(1'b0, 1'b1, 15'd0);
    chk("R4 wrap to 24574", {13'd2, 13'd6142, 1'b0, 1'b1});

    // load beats advance
    cyc(1'b1, 1'b1, 15'd3000);
    chk("R2 load priority", {13'd0, 13'd6143, 1'b0, 1'b0});
    cyc(1'b0, 1'b1, 15'd0);
    chk("R6 R7 q0 phase 3000", {13'd3000, 13'd3144, 1'b0, 1'b0});
    cyc(1'b0, 1'b1, 15'd0);
    chk("R6 R8 q0 phase 6000", {13'd6000, 13'd144, 1'b0, 1'b0});
    cyc(1'b0, 1'b1, 15'd0);
    chk("R6 R7 q1 phase 9000", {13'd3288, 13'd2856, 1'b1, 1'b0});

    // zero step
    cyc(1'b1, 1'b0, 15'd0);
    cyc(1'b0, 1'b1, 15'd0);
    cyc(1'b0, 1'b1, 15'd0);
    chk("R9 zero step", {13'd0, 13'd6143, 1'b0, 1'b0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule